// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer with a 32-bit register interface. A wide free-running counter advances on a slow timebase tick, supplied as a one-cycle enable at roughly 31.25 kHz. A 4-bit scale picks which 16-bit window of that counter is compared against a 16-bit threshold. When the window reaches the threshold, the block latches a sticky interrupt flag. Depending on its configuration, it can also clear its own counter and issue a single-cycle system reset request.

Writes are protected against runaway software. A write to any register other than the key register is accepted only when it directly follows a write of the unlock word to the key register. Each unlock admits exactly one write. The counter is serviced by writing a fixed magic word to the feed register. Reads need no key and return live state.

Register byte offsets: config 0x00, count 0x08, scaled count 0x10, feed 0x18, key 0x1C, threshold 0x20. Config fields: scale [3:0], reset enable [8], zero-on-match [9], run always [12], run while awake [13], pending [28].

Top module: `wdog_keyed`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `sys_rst_req` is 0.
- R2: A write to config, count, feed or threshold has no effect unless the unlock is held. A key write with any value other than 0x0051F15E does not grant the unlock.
- R3: A key write of 0x0051F15E grants the unlock. The next write to any other offset consumes it, whether or not that write takes effect, so a second write without a new key write is ignored.
- R4: An accepted write of 0x0D09F00D to the feed offset clears the counter. An accepted feed write of any other value leaves the counter unchanged.
- R5: The counter advances by one on a cycle with `tick` high only while running. It runs when config bit 12 is set, or when bit 13 is set and `core_awake` is high. Otherwise it holds.
- R6: The scaled count at 0x10 reads as the counter shifted right by config[3:0], truncated to 16 bits.
- R7: While running, a scaled count greater than or equal to the threshold sets pending (config bit 28, driven on `irq`) at the next edge. Pending stays set until it is cleared. It is never set while the counter is not running.
- R8: An accepted config write with bit 28 at 0 clears pending, unless a match occurs in the same cycle, in which case pending stays set.
- R9: With config bit 8 set, the first cycle of a match makes `sys_rst_req` high for exactly one cycle, one edge later. A match that persists gives no further pulse.
- R10: With config bit 9 set, a match clears the counter at the next edge, taking priority over a tick.
- R11: An accepted write to the count offset loads the counter. An accepted write to the threshold offset loads its 16 bits.
- R12: Reads need no unlock. The key offset reads 1 in bit 0 while the unlock is held, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per count step |
| core_awake | input | 1 | High while the core is awake |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Pending flag |
| sys_rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest state to reach is a match that is still present when software tries to clear pending. This exposes the priority of a match over the clear, and it needs the counter parked above the threshold with ticks stopped. The stimulus first drives ticks until the scaled window crosses the threshold. It then issues a keyed clear while the match persists, and only then raises the threshold and clears again. The reset-pulse and zero-on-match behaviour is reached by running continuous ticks against a small threshold, so that the counter wraps through two matches.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int          CNT_W    = 31,
  parameter int          CMP_W    = 16,
  parameter int          SCALE_W  = 4,
  parameter logic [31:0] KEY_WORD  = 32'h0051_F15E,
  parameter logic [31:0] FEED_WORD = 32'h0D09_F00D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        core_awake,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sys_rst_req
);
  localparam logic [5:0] A_CFG  = 6'h00;
  localparam logic [5:0] A_CNT  = 6'h08;
  localparam logic [5:0] A_SCL  = 6'h10;
  localparam logic [5:0] A_FEED = 6'h18;
  localparam logic [5:0] A_KEY  = 6'h1C;
  localparam logic [5:0] A_CMP  = 6'h20;

  logic [CNT_W-1:0]   cnt;
  logic [CMP_W-1:0]   cmp;
  logic [SCALE_W-1:0] scale;
  logic rst_en, zero_cmp, en_always, en_awake, pend, unlocked, hit_d;

  logic acc;
  assign acc = bus_wr && unlocked && (bus_addr != A_KEY);

  logic run;
  assign run = en_always || (en_awake && core_awake);

  logic [CNT_W-1:0] shifted;
  logic [CMP_W-1:0] scaled;
  assign shifted = cnt >> scale;
  assign scaled  = shifted[CMP_W-1:0];

  logic hit;
  assign hit = run && (scaled >= cmp);

  logic feed_ok;
  assign feed_ok = acc && (bus_addr == A_FEED) && (bus_wdata == FEED_WORD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) unlocked <= 1'b0;
    else if (bus_wr) unlocked <= (bus_addr == A_KEY) && (bus_wdata == KEY_WORD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (feed_ok) cnt <= '0;
    else if (acc && bus_addr == A_CNT) cnt <= bus_wdata[CNT_W-1:0];
    else if (hit && zero_cmp) cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scale <= '0; rst_en <= 1'b0; zero_cmp <= 1'b0;
      en_always <= 1'b0; en_awake <= 1'b0;
    end else if (acc && bus_addr == A_CFG) begin
      scale     <= bus_wdata[SCALE_W-1:0];
      rst_en    <= bus_wdata[8];
      zero_cmp  <= bus_wdata[9];
      en_always <= bus_wdata[12];
      en_awake  <= bus_wdata[13];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else if (hit) pend <= 1'b1;
    else if (acc && bus_addr == A_CFG) pend <= bus_wdata[28];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cmp <= '0;
    else if (acc && bus_addr == A_CMP) cmp <= bus_wdata[CMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hit_d <= 1'b0; sys_rst_req <= 1'b0;
    end else begin
      hit_d       <= hit;
      sys_rst_req <= rst_en && hit && !hit_d;
    end

  assign irq = pend;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[SCALE_W-1:0] = scale;
        bus_rdata[8]  = rst_en;
        bus_rdata[9]  = zero_cmp;
        bus_rdata[12] = en_always;
        bus_rdata[13] = en_awake;
        bus_rdata[28] = pend;
      end
      A_CNT:  bus_rdata[CNT_W-1:0] = cnt;
      A_SCL:  bus_rdata[CMP_W-1:0] = scaled;
      A_KEY:  bus_rdata[0] = unlocked;
      A_CMP:  bus_rdata[CMP_W-1:0] = cmp;
      default: bus_rdata = '0;
    endcase
  end

  a_r9_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  a_r3_unlock_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != A_KEY) |=> !unlocked);
  a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(acc && bus_addr == A_CFG)) |=> pend);
  a_r4_feed_clears: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt == '0));
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(cnt));
  a_r2_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked) |=> ($stable(scale) && $stable(cmp) && $stable(en_always)));
  a_r7_no_pend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pend && !(acc && bus_addr == A_CFG)) |=> !pend);
endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  localparam logic [5:0] CFG = 6'h00, CNT = 6'h08, SCL = 6'h10,
                         FEED = 6'h18, KEY = 6'h1C, CMP = 6'h20;
  localparam logic [31:0] KEYV = 32'h0051_F15E, FOOD = 32'h0D09_F00D;

  logic clk = 0, rst_n = 0, tick = 0, core_awake = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, sys_rst_req;

  wdog_keyed u_dut (.clk, .rst_n, .tick, .core_awake, .bus_wr, .bus_addr,
                    .bus_wdata, .bus_rdata, .irq, .sys_rst_req);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, pulses = 0;

  longint unsigned m_cnt = 0;
  int unsigned m_cmp = 0, m_scale = 0;
  bit m_rsten, m_zero, m_alw, m_awk, m_pend, m_unl, m_hitd, m_rst;

  function automatic logic [31:0] m_read(logic [5:0] a);
    case (a)
      CFG:  return m_scale | (32'(m_rsten) << 8) | (32'(m_zero) << 9) |
                   (32'(m_alw) << 12) | (32'(m_awk) << 13) | (32'(m_pend) << 28);
      CNT:  return 32'(m_cnt);
      SCL:  return 32'((m_cnt >> m_scale) & 64'hFFFF);
      KEY:  return 32'(m_unl);
      CMP:  return m_cmp;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] a);
    case (a)
      CFG: return "R2"; CNT: return "R5"; SCL: return "R6";
      KEY: return "R12"; CMP: return "R11"; default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_scale = 0; m_rsten = 0; m_zero = 0; m_alw = 0;
      m_awk = 0; m_pend = 0; m_unl = 0; m_hitd = 0; m_rst = 0;
    end else begin
      bit run, hit, acc;
      longint unsigned n_cnt;
      run = m_alw || (m_awk && core_awake);
      hit = run && (((m_cnt >> m_scale) & 64'hFFFF) >= m_cmp);
      acc = bus_wr && m_unl && bus_addr != KEY;
      n_cnt = m_cnt;
      if (acc && bus_addr == FEED && bus_wdata == FOOD) n_cnt = 0;
      else if (acc && bus_addr == CNT) n_cnt = bus_wdata & 32'h7FFF_FFFF;
      else if (hit && m_zero) n_cnt = 0;
      else if (run && tick) n_cnt = (m_cnt + 1) & 64'h7FFF_FFFF;
      m_rst = m_rsten && hit && !m_hitd;
      m_hitd = hit;
      if (hit) m_pend = 1;
      else if (acc && bus_addr == CFG) m_pend = bus_wdata[28];
      if (acc && bus_addr == CFG) begin
        m_scale = bus_wdata[3:0]; m_rsten = bus_wdata[8]; m_zero = bus_wdata[9];
        m_alw = bus_wdata[12]; m_awk = bus_wdata[13];
      end
      if (acc && bus_addr == CMP) m_cmp = bus_wdata[15:0];
      if (bus_wr) m_unl = (bus_addr == KEY) && (bus_wdata == KEYV);
      m_cnt = n_cnt;
    end
    #2;
    checks++;
    if (bus_rdata !== m_read(bus_addr) || irq !== m_pend || sys_rst_req !== m_rst) begin
      fails++;
      $display("FAIL %s/R7/R9 rdata=%h irq=%b rst=%b expected rdata=%h irq=%b rst=%b",
               tag_of(bus_addr), bus_rdata, irq, sys_rst_req, m_read(bus_addr), m_pend, m_rst);
    end
    if (sys_rst_req) pulses++;
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask
  task automatic kwr(logic [5:0] a, logic [31:0] d);
    wr(KEY, KEYV); wr(a, d);
  endtask
  task automatic rd(string tag, logic [5:0] a, logic [31:0] exp);
    bus_addr = a; #1; check(tag, bus_rdata, exp);
  endtask
  task automatic ticks(int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 config", CFG, 0); rd("R1 count", CNT, 0);
    check("R1 irq", irq, 0); check("R1 rst", sys_rst_req, 0);

    wr(CFG, 32'h1000);            rd("R2 no key", CFG, 0);
    wr(KEY, 32'h123);             rd("R2 bad key", KEY, 0);
    wr(CFG, 32'h1000);            rd("R2 bad key cfg", CFG, 0);
    wr(KEY, KEYV);                rd("R12 key held", KEY, 1);
    wr(CMP, 32'h10);              rd("R11 cmp", CMP, 32'h10);
    rd("R3 consumed", KEY, 0);
    wr(CMP, 32'h20);              rd("R3 second write", CMP, 32'h10);

    kwr(CNT, 100);                rd("R11 count load", CNT, 100);
    ticks(5);                     rd("R5 idle hold", CNT, 100);
    check("R7 no match idle", irq, 0);
    kwr(CNT, 0);
    kwr(CFG, 32'h2000);
    ticks(5);                     rd("R5 asleep", CNT, 0);
    core_awake = 1; ticks(5);     rd("R5 awake", CNT, 5);
    core_awake = 0;
    kwr(CFG, 32'h1002);
    ticks(7);                     rd("R6 scaled", SCL, 3);
    kwr(FEED, 32'h1234);          rd("R4 wrong food", CNT, 12);
    kwr(FEED, FOOD);              rd("R4 fed", CNT, 0);

    ticks(64);                    check("R7 before match", irq, 0);
    @(negedge clk);               check("R7 match", irq, 1);
    ticks(3);                     check("R7 sticky", irq, 1);
    kwr(CFG, 32'h1002);           check("R8 match wins", irq, 1);
    kwr(CMP, 32'hFFFF);
    kwr(CFG, 32'h1002);           check("R8 cleared", irq, 0);

    kwr(CNT, 0);
    kwr(CMP, 4);
    kwr(CFG, 32'h1300);
    begin
      int p0;
      p0 = pulses;
      ticks(12);
      @(negedge clk);
      check("R9 pulse count", pulses - p0, 2);
    end
    rd("R10 zeroed", CNT, 2);
    check("R7 set by match", irq, 1);
    summary();
  end
endmodule